// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block owns the single bidirectional command wire of an SD/MMC card bus and runs in the card clock domain that the host supplies. Software presents a 6-bit command index, a 32-bit argument and a response kind, then pulses `start`. The engine sends a 48-bit command frame with a computed CRC7 and releases the wire. Unless no response was requested, it then watches the returned line for a card reply and captures a 48-bit or 136-bit response while checking that reply's CRC7.

The engine never decodes command meaning, so the response kind must come from software. The pad-level tri-state buffer sits outside the block. The engine provides a drive value, an output enable and a sampled input. Completion is a one-cycle `done` pulse. The `timeout` and `crc_err` status flags stay valid until the next accepted command.

Top module: `sdmmc_cmd_engine`

## Requirements
- R1: After reset, `cmd_oe`, `busy`, `done`, `timeout` and `crc_err` are all 0 and `rsp_frame` is all zeros.
- R2: When `start` is sampled high while idle, the engine drives 48 bits on `cmd_out`, MSB first and one bit per clock, beginning in the cycle after that edge. The frame is start bit 0, then 1, then `cmd_index[5:0]`, then `cmd_arg[31:0]`, then the 7 CRC bits, then an end bit 1.
- R3: The command CRC7 uses the polynomial x^7 + x^3 + 1 with an all-zero initial value, taken over the first 40 frame bits. Index 0 with argument 0 gives 7'h4A, and index 17 with argument 0 gives 7'h2A.
- R4: `cmd_oe` is 1 for exactly the 48 command bit periods and 0 at every other time.
- R5: With `rsp_kind` = 2'b00 (no response), `done` pulses in the cycle right after the last command bit, and the engine does not look at `cmd_in`.
- R6: For any other response kind, the engine samples `cmd_in` on up to 64 clock edges after the command ends, waiting for a 0 start bit. A start bit on the 64th edge is still accepted. If none arrives, `done` pulses together with `timeout` = 1.
- R7: With `rsp_kind` = 2'b01 (short), 48 bits are captured MSB first into `rsp_frame[47:0]`, with the upper bits 0. `crc_err` is set if the CRC7 of response bits 47:8 differs from bits 7:1.
- R8: With `rsp_kind` = 2'b10 or 2'b11 (long), 136 bits are captured into `rsp_frame[135:0]`. `crc_err` is set if the CRC7 of response bits 127:8 differs from bits 7:1. The eight header bits are not included.
- R9: `busy` is 1 from the cycle after an accepted `start` until the completion cycle, and `done` is a single-cycle pulse in which `busy` is already 0. `timeout` and `crc_err` are updated with `done` and hold until the next accepted `start` clears them.
- R10: A `start` pulse while `busy` is 1 is ignored. The command frame in progress and the later outcome are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; all bits launch and are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to send a command; honoured only while idle |
| cmd_index | input | 6 | Command index placed in the frame |
| cmd_arg | input | 32 | Command argument placed in the frame |
| rsp_kind | input | 2 | 00 none, 01 short 48-bit, 1x long 136-bit |
| cmd_in | input | 1 | Sampled level of the command wire |
| cmd_out | output | 1 | Value to drive on the command wire (1 when released) |
| cmd_oe | output | 1 | Output enable for the command wire pad |
| busy | output | 1 | A command or response is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | No response start bit arrived in the window |
| crc_err | output | 1 | Received response failed its CRC7 check |
| rsp_frame | output | 136 | Captured response bits, right-aligned |

## Verification
A wrong frame counter or shift register appears on `cmd_out` within one bit period, because every driven bit is compared in the cycle it is launched. A wrong enable length shows up on `cmd_oe` at the first or 49th bit. A wrong count in the response window moves the `done` and `timeout` pulse by at least one cycle, and the per-cycle comparison catches that shift at the boundary delays of 63 and 64 idle edges. A wrong CRC span or register state changes `crc_err` at the `done` cycle, for both clean and corrupted replies of each length.

// File: rtl/sdmmc_cmd_pkg.sv
// Package: shared constants, state type and CRC7 step function for the
// command line engine. Assumes MSB-first serial order on the wire.
package sdmmc_cmd_pkg;

    localparam int          CRC_W     = 7;
    localparam logic [6:0]  CRC7_TAPS = 7'h09;   // x^3 + 1 terms of x^7 + x^3 + 1
    localparam logic [1:0]  KIND_NONE = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_RECV = 2'd3
    } cmd_state_e;

    // Advance a CRC7 register by one serial input bit.
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC7_TAPS : '0);
    endfunction

endpackage

// File: rtl/sdmmc_cmd_tx.sv
// Command serializer: builds the frame (start, direction, index, argument,
// CRC7, end) when loaded and shifts it out MSB first, one bit per clock.
// Assumes the controller asserts load and shift in mutually exclusive cycles.
module sdmmc_cmd_tx
    import sdmmc_cmd_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic             bit_o,
    output logic             last_o
);
    localparam int HDR_W   = 2 + IDX_W + ARG_W;
    localparam int FRAME_W = HDR_W + CRC_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FRAME_W - 1);

    logic [HDR_W-1:0]   hdr;
    logic [CRC_W-1:0]   crc;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] sreg_q;
    logic [CNT_W-1:0]   cnt_q;

    // Assemble the header and fold it through the CRC7 generator.
    always_comb begin
        hdr = {2'b01, idx, arg};
        crc = '0;
        for (int i = HDR_W - 1; i >= 0; i--) begin
            crc = crc7_step(crc, hdr[i]);
        end
        frame = {hdr, crc, 1'b1};
    end

    // Hold the frame and count remaining bits while it is shifted out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '1;
            cnt_q  <= '0;
        end else if (load) begin
            sreg_q <= frame;
            cnt_q  <= CNT_TOP;
        end else if (shift) begin
            sreg_q <= {sreg_q[FRAME_W-2:0], 1'b1};
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign bit_o  = sreg_q[FRAME_W-1];
    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sdmmc_cmd_rx.sv
// Response deserializer: shifts sampled bits into a right-aligned frame,
// counts them and runs CRC7 over the protected span chosen by the length.
// Assumes clear comes before the first sample of each response.
module sdmmc_cmd_rx
    import sdmmc_cmd_pkg::*;
#(
    parameter int SHORT_W  = 48,
    parameter int LONG_W   = 136,
    parameter int LONG_HDR = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        sample,
    input  logic                        bit_i,
    input  logic                        long_mode,
    output logic [LONG_W-1:0]           frame_o,
    output logic [$clog2(LONG_W+1)-1:0] count_o,
    output logic                        match_o
);
    localparam int CNT_W = $clog2(LONG_W + 1);
    localparam logic [CNT_W-1:0] SHORT_HI = CNT_W'(SHORT_W - CRC_W - 1);
    localparam logic [CNT_W-1:0] LONG_LO  = CNT_W'(LONG_HDR);
    localparam logic [CNT_W-1:0] LONG_HI  = CNT_W'(LONG_W - CRC_W - 1);

    logic [LONG_W-1:0] frame_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CRC_W-1:0]  crc_q;
    logic              in_span;

    // Decide whether the bit now arriving belongs to the CRC-protected span.
    always_comb begin
        if (long_mode) begin
            in_span = (cnt_q >= LONG_LO) && (cnt_q < LONG_HI);
        end else begin
            in_span = (cnt_q < SHORT_HI);
        end
    end

    // Capture bits, count them and update the running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            frame_q <= '0;
            cnt_q   <= '0;
            crc_q   <= '0;
        end else if (sample) begin
            frame_q <= {frame_q[LONG_W-2:0], bit_i};
            cnt_q   <= cnt_q + 1'b1;
            if (in_span) begin
                crc_q <= crc7_step(crc_q, bit_i);
            end
        end
    end

    assign frame_o = frame_q;
    assign count_o = cnt_q;
    // Before the end bit arrives, the CRC field occupies the low bits.
    assign match_o = (frame_q[CRC_W-1:0] == crc_q);

endmodule

// File: rtl/sdmmc_cmd_fsm.sv
// Sequencer: accepts a command request, times the send phase, bounds the
// response wait window and posts completion status.
// Assumes tx_last and rx_count come from the serializer and deserializer.
module sdmmc_cmd_fsm
    import sdmmc_cmd_pkg::*;
#(
    parameter int SHORT_W     = 48,
    parameter int LONG_W      = 136,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [1:0]                  rsp_kind,
    input  logic                        cmd_in,
    input  logic                        tx_last,
    input  logic [$clog2(LONG_W+1)-1:0] rx_count,
    input  logic                        rx_match,
    output logic                        tx_load,
    output logic                        tx_shift,
    output logic                        rx_clear,
    output logic                        rx_sample,
    output logic                        rx_long,
    output logic                        drive,
    output logic                        busy,
    output logic                        done,
    output logic                        timeout,
    output logic                        crc_err
);
    localparam int CNT_W  = $clog2(LONG_W + 1);
    localparam int WAIT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [WAIT_W-1:0] WAIT_MAX   = WAIT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0]  SHORT_LAST = CNT_W'(SHORT_W - 1);
    localparam logic [CNT_W-1:0]  LONG_LAST  = CNT_W'(LONG_W - 1);

    cmd_state_e        state_q;
    logic [WAIT_W-1:0] wait_q;
    logic              long_q;
    logic              none_q;
    logic              done_q;
    logic              to_q;
    logic              ce_q;
    logic [CNT_W-1:0]  last_idx;

    // Index of the final response bit for the latched length.
    assign last_idx = long_q ? LONG_LAST : SHORT_LAST;

    // Strobes to the datapath derived from the current state.
    always_comb begin
        tx_load   = (state_q == ST_IDLE) && start;
        tx_shift  = (state_q == ST_SEND) && !tx_last;
        rx_clear  = tx_load;
        rx_sample = ((state_q == ST_WAIT) && !cmd_in) || (state_q == ST_RECV);
    end

    // State transitions, wait window counter and completion status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
            long_q  <= 1'b0;
            none_q  <= 1'b0;
            done_q  <= 1'b0;
            to_q    <= 1'b0;
            ce_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SEND;
                        long_q  <= rsp_kind[1];
                        none_q  <= (rsp_kind == KIND_NONE);
                        to_q    <= 1'b0;
                        ce_q    <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (tx_last) begin
                        if (none_q) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_WAIT;
                            wait_q  <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!cmd_in) begin
                        state_q <= ST_RECV;
                    end else if (wait_q == WAIT_MAX) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        to_q    <= 1'b1;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_RECV: begin
                    if (rx_count == last_idx) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        ce_q    <= !rx_match;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rx_long = long_q;
    assign drive   = (state_q == ST_SEND);
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign timeout = to_q;
    assign crc_err = ce_q;

endmodule

// File: rtl/sdmmc_cmd_engine.sv
// Top of the command line engine: ties the sequencer, serializer and
// deserializer together and presents the pad-side drive/enable pair.
// Assumes clk is the card clock and cmd_in is already synchronous to it.
module sdmmc_cmd_engine
    import sdmmc_cmd_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int ARG_W       = 32,
    parameter int SHORT_W     = 48,
    parameter int LONG_W      = 136,
    parameter int LONG_HDR    = 8,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic [1:0]        rsp_kind,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic              crc_err,
    output logic [LONG_W-1:0] rsp_frame
);
    localparam int CNT_W = $clog2(LONG_W + 1);

    logic             tx_load;
    logic             tx_shift;
    logic             tx_bit;
    logic             tx_last;
    logic             rx_clear;
    logic             rx_sample;
    logic             rx_long;
    logic [CNT_W-1:0] rx_count;
    logic             rx_match;
    logic             drive;

    sdmmc_cmd_fsm #(
        .SHORT_W     (SHORT_W),
        .LONG_W      (LONG_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rsp_kind  (rsp_kind),
        .cmd_in    (cmd_in),
        .tx_last   (tx_last),
        .rx_count  (rx_count),
        .rx_match  (rx_match),
        .tx_load   (tx_load),
        .tx_shift  (tx_shift),
        .rx_clear  (rx_clear),
        .rx_sample (rx_sample),
        .rx_long   (rx_long),
        .drive     (drive),
        .busy      (busy),
        .done      (done),
        .timeout   (timeout),
        .crc_err   (crc_err)
    );

    sdmmc_cmd_tx #(
        .IDX_W (IDX_W),
        .ARG_W (ARG_W)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tx_load),
        .shift  (tx_shift),
        .idx    (cmd_index),
        .arg    (cmd_arg),
        .bit_o  (tx_bit),
        .last_o (tx_last)
    );

    sdmmc_cmd_rx #(
        .SHORT_W  (SHORT_W),
        .LONG_W   (LONG_W),
        .LONG_HDR (LONG_HDR)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_clear),
        .sample    (rx_sample),
        .bit_i     (cmd_in),
        .long_mode (rx_long),
        .frame_o   (rsp_frame),
        .count_o   (rx_count),
        .match_o   (rx_match)
    );

    // Pad interface: drive only during the send phase, idle high otherwise.
    assign cmd_oe  = drive;
    assign cmd_out = drive ? tx_bit : 1'b1;

endmodule

// File: rtl/sdmmc_cmd_engine_chk.sv
// Checker: temporal properties over the engine's ports, bound to the top.
module sdmmc_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic cmd_out,
    input logic cmd_oe,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic crc_err
);
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_oe);

    p_start_accepted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && cmd_oe && !cmd_out));

    p_first_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);

    p_oe_within_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> busy);

    p_timeout_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done);

    p_crc_flag_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout && crc_err));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(timeout) && $stable(crc_err)));

endmodule

bind sdmmc_cmd_engine sdmmc_cmd_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmd_out (cmd_out),
    .cmd_oe  (cmd_oe),
    .busy    (busy),
    .done    (done),
    .timeout (timeout),
    .crc_err (crc_err)
);

// File: tb/tb_sdmmc_cmd_engine.sv
// Bench: behavioural card model plus a per-cycle reference of the engine.
module tb_sdmmc_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 64;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [5:0]   cmd_index;
    logic [31:0]  cmd_arg;
    logic [1:0]   rsp_kind;
    logic         cmd_in;
    logic         cmd_out;
    logic         cmd_oe;
    logic         busy;
    logic         done;
    logic         timeout;
    logic         crc_err;
    logic [135:0] rsp_frame;

    int n_chk  = 0;
    int n_fail = 0;

    sdmmc_cmd_engine dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_index (cmd_index),
        .cmd_arg   (cmd_arg),
        .rsp_kind  (rsp_kind),
        .cmd_in    (cmd_in),
        .cmd_out   (cmd_out),
        .cmd_oe    (cmd_oe),
        .busy      (busy),
        .done      (done),
        .timeout   (timeout),
        .crc_err   (crc_err),
        .rsp_frame (rsp_frame)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // CRC7 by polynomial long division of msg[n-1:0] * x^7 by 0x89.
    function automatic logic [6:0] ref_crc(input logic [135:0] msg, input int n);
        logic [142:0] w;
        w = {msg, 7'b0};
        for (int i = n + 6; i >= 7; i--) begin
            if (w[i]) w[i -: 8] = w[i -: 8] ^ 8'h89;
        end
        return w[6:0];
    endfunction

    // Reference model state.
    int           m_state;
    int           m_wait;
    int           m_rxn;
    bit           m_long;
    bit           m_none;
    bit           tx_q[$];
    logic [135:0] m_rx;
    logic         e_oe, e_out, e_busy, e_done, e_to, e_ce;
    logic [135:0] e_frame;
    logic [47:0]  obs;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_wait = 0; m_rxn = 0; m_long = 0; m_none = 0;
            tx_q.delete(); m_rx = '0;
            e_oe = 0; e_out = 1; e_busy = 0; e_done = 0; e_to = 0; e_ce = 0;
            e_frame = '0;
        end else begin
            e_done = 0;
            case (m_state)
                0: if (start) begin
                    logic [39:0] h;
                    logic [47:0] f;
                    h = {2'b01, cmd_index, cmd_arg};
                    f = {h, ref_crc({96'b0, h}, 40), 1'b1};
                    tx_q.delete();
                    for (int i = 47; i >= 0; i--) tx_q.push_back(f[i]);
                    m_long = rsp_kind[1];
                    m_none = (rsp_kind == 2'b00);
                    e_to = 0; e_ce = 0; e_busy = 1; e_oe = 1;
                    e_out = tx_q.pop_front();
                    m_rx = '0; m_rxn = 0;
                    m_state = 1;
                end
                1: if (tx_q.size() == 0) begin
                    e_oe = 0;
                    if (m_none) begin
                        m_state = 0; e_busy = 0; e_done = 1;
                    end else begin
                        m_state = 2; m_wait = 0;
                    end
                end else begin
                    e_out = tx_q.pop_front();
                end
                2: if (cmd_in == 1'b0) begin
                    m_rx = {m_rx[134:0], 1'b0}; m_rxn = 1; m_state = 3;
                end else if (m_wait == WAIT_LIMIT - 1) begin
                    m_state = 0; e_busy = 0; e_done = 1; e_to = 1;
                end else begin
                    m_wait++;
                end
                3: begin
                    m_rx = {m_rx[134:0], cmd_in};
                    m_rxn++;
                    if (m_rxn == (m_long ? 136 : 48)) begin
                        if (m_long)
                            e_ce = (ref_crc({16'b0, m_rx[127:8]}, 120) != m_rx[7:1]);
                        else
                            e_ce = (ref_crc({96'b0, m_rx[47:8]}, 40) != m_rx[7:1]);
                        e_frame = m_rx;
                        m_state = 0; e_busy = 0; e_done = 1;
                    end
                end
                default: m_state = 0;
            endcase
        end
    end

    // Per-cycle comparison, sampled after the edge has settled.
    always @(posedge clk) begin
        #1;
        check(cmd_oe === e_oe, "R4 output enable", 136'(cmd_oe), 136'(e_oe));
        if (e_oe) check(cmd_out === e_out, "R2 command bit", 136'(cmd_out), 136'(e_out));
        if (cmd_oe) obs = {obs[46:0], cmd_out};
        check(busy === e_busy, "R9 busy", 136'(busy), 136'(e_busy));
        check(done === e_done, "R9 done pulse", 136'(done), 136'(e_done));
        check(timeout === e_to, "R6 timeout flag", 136'(timeout), 136'(e_to));
        check(crc_err === e_ce, "R7 R8 crc flag", 136'(crc_err), 136'(e_ce));
        if (e_done && !m_none && !e_to)
            check(rsp_frame === e_frame, "R7 R8 captured frame", rsp_frame, e_frame);
    end

    // One command with an optional card reply; named checks at completion.
    task automatic run(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                       input int delay, input bit corrupt, input bit glitch);
        logic [39:0]  h;
        logic [47:0]  exp_cmd;
        logic [135:0] resp;
        int           rlen;
        h = {2'b01, idx, arg};
        exp_cmd = {h, ref_crc({96'b0, h}, 40), 1'b1};
        rlen = kind[1] ? 136 : 48;
        if (kind[1]) begin
            logic [119:0] pay;
            logic [6:0]   c;
            pay = {arg, ~arg, arg ^ 32'h5A5A_C3C3, arg[23:0]};
            c = ref_crc({16'b0, pay}, 120) ^ (corrupt ? 7'h10 : 7'h00);
            resp = {2'b00, 6'h3F, pay, c, 1'b1};
        end else begin
            logic [39:0] rh;
            logic [6:0]  c;
            rh = {2'b00, idx, arg};
            c = ref_crc({96'b0, rh}, 40) ^ (corrupt ? 7'h01 : 7'h00);
            resp = {88'b0, rh, c, 1'b1};
        end
        obs = '0;
        @(negedge clk);
        cmd_index = idx; cmd_arg = arg; rsp_kind = kind; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (kind != 2'b00) begin
            for (int k = 1; k <= 48 + delay; k++) begin
                if (glitch && k == 10) begin
                    start = 1'b1; cmd_index = 6'h3F; rsp_kind = 2'b00;
                end else if (glitch && k == 11) begin
                    start = 1'b0; cmd_index = idx; rsp_kind = kind;
                end
                @(negedge clk);
            end
            if (delay < WAIT_LIMIT) begin
                for (int i = rlen - 1; i >= 0; i--) begin
                    cmd_in = resp[i];
                    @(negedge clk);
                end
                cmd_in = 1'b1;
            end
        end
        while (m_state != 0) @(negedge clk);
        @(negedge clk);
        check(obs === exp_cmd, "R2 command frame", 136'(obs), 136'(exp_cmd));
        if (kind == 2'b00) begin
            check(!timeout && !crc_err, "R5 no-response status", 136'({timeout, crc_err}), 136'(0));
        end else if (delay >= WAIT_LIMIT) begin
            check(timeout === 1'b1, "R6 timeout raised", 136'(timeout), 136'(1));
        end else if (kind[1]) begin
            check(crc_err === corrupt, "R8 long crc result", 136'(crc_err), 136'(corrupt));
            check(rsp_frame === resp, "R8 long capture", rsp_frame, resp);
        end else begin
            check(crc_err === corrupt, "R7 short crc result", 136'(crc_err), 136'(corrupt));
            check(rsp_frame === resp, "R7 short capture", rsp_frame, resp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; cmd_index = '0; cmd_arg = '0; rsp_kind = 2'b00; cmd_in = 1'b1;
        repeat (3) @(negedge clk);
        check(cmd_oe === 1'b0 && busy === 1'b0, "R1 reset drive", 136'({cmd_oe, busy}), 136'(0));
        check(done === 1'b0 && timeout === 1'b0 && crc_err === 1'b0, "R1 reset status",
              136'({done, timeout, crc_err}), 136'(0));
        check(rsp_frame === '0, "R1 reset frame", rsp_frame, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 and R3: no response, known CRC 7'h4A
        run(6'd0, 32'h0, 2'b00, 0, 1'b0, 1'b0);
        check(obs[7:1] === 7'h4A, "R3 crc of index 0", 136'(obs[7:1]), 136'(7'h4A));
        // R7 and R3: short reply, known CRC 7'h2A
        run(6'd17, 32'h0, 2'b01, 3, 1'b0, 1'b0);
        check(obs[7:1] === 7'h2A, "R3 crc of index 17", 136'(obs[7:1]), 136'(7'h2A));
        run(6'd13, 32'hDEAD_BEEF, 2'b01, 0, 1'b1, 1'b0);   // R7 corrupted
        run(6'd2, 32'h1234_5678, 2'b10, 10, 1'b0, 1'b0);   // R8 clean
        run(6'd9, 32'hA5A5_0F0F, 2'b11, 1, 1'b1, 1'b0);    // R8 corrupted, kind 11
        run(6'd55, 32'h0000_FFFF, 2'b01, 63, 1'b0, 1'b0);  // R6 last edge accepted
        run(6'd41, 32'h8000_0001, 2'b01, 64, 1'b0, 1'b0);  // R6 timeout
        repeat (6) @(negedge clk);
        check(timeout === 1'b1, "R9 timeout held", 136'(timeout), 136'(1));
        run(6'd24, 32'h0BAD_F00D, 2'b01, 2, 1'b0, 1'b1);   // R10 start ignored
        check(timeout === 1'b0, "R9 flag cleared by start", 136'(timeout), 136'(0));
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule